// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Sequencer

This block is the bus-master front end that opens every transaction on an open-drain single-wire bus. On a start request it pulls the line low for a reset pulse and then lets it go. At a fixed point after the release it takes a single sample of the line to see whether a slave is answering with a presence pulse. It then waits out the rest of the reset-high window before it reports that it is finished. The line input passes through a two-flop synchronizer before it is sampled.

Two bus speeds are supported. At standard speed the reset low lasts at least 480 µs, which also returns every attached slave to standard speed. At the fast (overdrive) speed the reset low is 70 µs, short enough that the slaves stay in overdrive. The block never produces a low between those two limits, because a slave's speed after such a pulse is undefined. A mixed-population flag stretches the high window so that slower device families on the same wire have time to recover. All timing is given in microseconds and scaled by a clock-cycles-per-microsecond parameter. The speed and mixed flags are captured when a request is accepted.

Top module: `swb_reset_seq`

## Requirements
- R1: When `start_i` is high in a cycle where `busy_o` is low, `line_oe_o` (1 = pull the line low) and `busy_o` are both high from the next cycle on. `line_oe_o` is never high while `busy_o` is low.
- R2: With `overdrive_i` = 0 at the start, `line_oe_o` stays high for exactly STD_LOW_US × CLKS_PER_US cycles. STD_LOW_US is at least 480.
- R3: With `overdrive_i` = 1 at the start, `line_oe_o` stays high for exactly OD_LOW_US × CLKS_PER_US cycles. OD_LOW_US is 70 by default and at most 80.
- R4: Each low pulse driven on the line lasts either at most 80 µs or at least 480 µs. No pulse falls between those limits.
- R5: The block samples the synchronized line once, SAMP_US × CLKS_PER_US cycles after release. SAMP_US is 70 at standard speed and 9 at overdrive. A low reading sets `present_o` to 1 and a high reading sets it to 0. A slave pulse that ends well before the sample point leaves `present_o` at 0. `present_o` changes only while `busy_o` is high.
- R6: With the mixed flag clear, the time from release to `done_o` is STD_HIGH_US (410 µs) at standard speed and OD_HIGH_US (40 µs) at overdrive.
- R7: With `mixed_i` = 1 at the start, the time from release to `done_o` is raised to at least 480 µs at standard speed and at least 48 µs at overdrive.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The low and high lengths of the sequence already running do not change.
- R9: `done_o` is a one-cycle pulse in the first cycle with `busy_o` low. `present_o` keeps its value until the next accepted start, which clears it.
- R10: While `rst_n` is low, `line_oe_o`, `busy_o`, `done_o` and `present_o` are all 0. This also holds when reset is asserted in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a reset/presence sequence |
| overdrive_i | input | 1 | 1 = fast speed, 0 = standard speed (captured at start) |
| mixed_i | input | 1 | 1 = stretch the high window for mixed device populations (captured at start) |
| line_i | input | 1 | Raw bus line level, synchronized internally |
| line_oe_o | output | 1 | 1 = pull the open-drain line low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence strobe |
| present_o | output | 1 | 1 = a slave presence pulse was seen at the sample point |

## Verification
The assertions check several rules on every cycle:
- the line is never pulled low outside a busy sequence;
- no low pulse lands in the forbidden 80–480 µs band;
- `done_o` lasts one cycle and only while idle;
- the presence flag moves only during a sequence.

The exact pulse and window lengths for each speed and mixed setting can only be shown by the bench's scenarios. The same holds for the effect of placing the slave's pulse before or on the sample point, for ignoring a start while busy, and for resetting mid-sequence.

// File: rtl/swb_pkg.sv
package swb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_SAMP = 2'd2,
      ST_HOLD = 2'd3
   } swb_state_e;

   typedef struct packed {
      logic od;
      logic mixed;
   } swb_mode_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   initial begin
      if (STAGES < 2) $error("swb_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/swb_timer.sv
module swb_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load_i)      cnt <= load_val_i;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero_o = (cnt == '0);
endmodule

// File: rtl/swb_timing.sv
module swb_timing
   import swb_pkg::*;
#(
   parameter int CLKS_PER_US = 2,
   parameter int STD_LOW_US  = 480,
   parameter int OD_LOW_US   = 70,
   parameter int STD_SAMP_US = 70,
   parameter int OD_SAMP_US  = 9,
   parameter int STD_HIGH_US = 410,
   parameter int OD_HIGH_US  = 40,
   parameter int MIX_STD_US  = 480,
   parameter int MIX_OD_US   = 48,
   parameter bit MIXED_EN    = 1'b1,
   parameter int CNT_W       = 12
) (
   input  swb_mode_t        mode_i,
   output logic [CNT_W-1:0] low_cyc_o,
   output logic [CNT_W-1:0] samp_cyc_o,
   output logic [CNT_W-1:0] rest_cyc_o
);
   localparam int unsigned STD_LOW_C  = STD_LOW_US  * CLKS_PER_US;
   localparam int unsigned OD_LOW_C   = OD_LOW_US   * CLKS_PER_US;
   localparam int unsigned STD_SAMP_C = STD_SAMP_US * CLKS_PER_US;
   localparam int unsigned OD_SAMP_C  = OD_SAMP_US  * CLKS_PER_US;
   localparam int unsigned STD_HI_C   = STD_HIGH_US * CLKS_PER_US;
   localparam int unsigned OD_HI_C    = OD_HIGH_US  * CLKS_PER_US;
   localparam int unsigned STD_MIX_C  = max_u(STD_HI_C, MIX_STD_US * CLKS_PER_US);
   localparam int unsigned OD_MIX_C   = max_u(OD_HI_C,  MIX_OD_US  * CLKS_PER_US);

   initial begin
      if (OD_LOW_US > 80)         $error("swb_timing: overdrive reset low must not exceed 80 us");
      if (STD_LOW_US < 480)       $error("swb_timing: standard reset low must be at least 480 us");
      if (STD_SAMP_US >= STD_HIGH_US) $error("swb_timing: standard sample point outside high window");
      if (OD_SAMP_US >= OD_HIGH_US)   $error("swb_timing: overdrive sample point outside high window");
      if (OD_SAMP_US * CLKS_PER_US < 4) $error("swb_timing: sample point too close to release");
      if (STD_MIX_C >= (1 << CNT_W) || STD_LOW_C >= (1 << CNT_W))
         $error("swb_timing: CNT_W too small");
   end

   logic [CNT_W-1:0] hi_std, hi_od;

   generate
      if (MIXED_EN) begin : g_mixed
         assign hi_std = mode_i.mixed ? CNT_W'(STD_MIX_C) : CNT_W'(STD_HI_C);
         assign hi_od  = mode_i.mixed ? CNT_W'(OD_MIX_C)  : CNT_W'(OD_HI_C);
      end else begin : g_plain
         assign hi_std = CNT_W'(STD_HI_C);
         assign hi_od  = CNT_W'(OD_HI_C);
      end
   endgenerate

   always_comb begin
      if (mode_i.od) begin
         low_cyc_o  = CNT_W'(OD_LOW_C);
         samp_cyc_o = CNT_W'(OD_SAMP_C);
         rest_cyc_o = hi_od - CNT_W'(OD_SAMP_C);
      end else begin
         low_cyc_o  = CNT_W'(STD_LOW_C);
         samp_cyc_o = CNT_W'(STD_SAMP_C);
         rest_cyc_o = hi_std - CNT_W'(STD_SAMP_C);
      end
   end
endmodule

// File: rtl/swb_reset_seq.sv
module swb_reset_seq
   import swb_pkg::*;
#(
   parameter int CLKS_PER_US = 2,
   parameter int STD_LOW_US  = 480,
   parameter int OD_LOW_US   = 70,
   parameter int STD_SAMP_US = 70,
   parameter int OD_SAMP_US  = 9,
   parameter int STD_HIGH_US = 410,
   parameter int OD_HIGH_US  = 40,
   parameter int MIX_STD_US  = 480,
   parameter int MIX_OD_US   = 48,
   parameter bit MIXED_EN    = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic overdrive_i,
   input  logic mixed_i,
   input  logic line_i,
   output logic line_oe_o,
   output logic busy_o,
   output logic done_o,
   output logic present_o
);
   localparam int unsigned MAX_US = max_u(max_u(STD_LOW_US, STD_HIGH_US), MIX_STD_US);
   localparam int CNT_W = $clog2(MAX_US * CLKS_PER_US + 1);

   swb_state_e       state_q, state_d;
   swb_mode_t        mode_q, mode_sel;
   logic             line_s;
   logic             tmr_zero, tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic [CNT_W-1:0] low_cyc, samp_cyc, rest_cyc;
   logic             done_d, pres_q;

   swb_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_i),
      .q_o   (line_s)
   );

   assign mode_sel = (state_q == ST_IDLE) ? swb_mode_t'{od: overdrive_i, mixed: mixed_i} : mode_q;

   swb_timing #(
      .CLKS_PER_US (CLKS_PER_US),
      .STD_LOW_US  (STD_LOW_US),
      .OD_LOW_US   (OD_LOW_US),
      .STD_SAMP_US (STD_SAMP_US),
      .OD_SAMP_US  (OD_SAMP_US),
      .STD_HIGH_US (STD_HIGH_US),
      .OD_HIGH_US  (OD_HIGH_US),
      .MIX_STD_US  (MIX_STD_US),
      .MIX_OD_US   (MIX_OD_US),
      .MIXED_EN    (MIXED_EN),
      .CNT_W       (CNT_W)
   ) u_timing (
      .mode_i     (mode_sel),
      .low_cyc_o  (low_cyc),
      .samp_cyc_o (samp_cyc),
      .rest_cyc_o (rest_cyc)
   );

   swb_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      done_d   = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            state_d  = ST_LOW;
            tmr_load = 1'b1;
            tmr_val  = low_cyc - 1'b1;
         end
         ST_LOW: if (tmr_zero) begin
            state_d  = ST_SAMP;
            tmr_load = 1'b1;
            tmr_val  = samp_cyc - 1'b1;
         end
         ST_SAMP: if (tmr_zero) begin
            state_d  = ST_HOLD;
            tmr_load = 1'b1;
            tmr_val  = rest_cyc - 1'b1;
         end
         ST_HOLD: if (tmr_zero) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= '0;
         done_o  <= 1'b0;
         pres_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_o  <= done_d;
         if (state_q == ST_IDLE && start_i) begin
            mode_q <= mode_sel;
            pres_q <= 1'b0;
         end
         if (state_q == ST_SAMP && tmr_zero) pres_q <= ~line_s;
      end
   end

   assign line_oe_o = (state_q == ST_LOW);
   assign busy_o    = (state_q != ST_IDLE);
   assign present_o = pres_q;
endmodule

// File: rtl/swb_reset_seq_chk.sv
module swb_reset_seq_chk #(
   parameter int OD_MAX_CYC  = 160,
   parameter int STD_MIN_CYC = 960
) (
   input logic clk,
   input logic rst_n,
   input logic line_oe_o,
   input logic busy_o,
   input logic done_o,
   input logic present_o
);
   int unsigned low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_run <= 0;
      else if (line_oe_o)  low_run <= low_run + 1;
      else                 low_run <= 0;
   end

   assert_oe_needs_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe_o |-> busy_o);

   assert_low_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(line_oe_o)) |-> ($past(low_run) + 1 <= OD_MAX_CYC || $past(low_run) + 1 >= STD_MIN_CYC));

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_present_moves_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (present_o != $past(present_o)) |-> busy_o);
endmodule

bind swb_reset_seq swb_reset_seq_chk #(
   .OD_MAX_CYC  (80 * CLKS_PER_US),
   .STD_MIN_CYC (480 * CLKS_PER_US)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_oe_o (line_oe_o),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .present_o (present_o)
);

// File: tb/swb_reset_seq_test.sv
module swb_reset_seq_test;
   localparam int CPU = 2;
   localparam int NV  = 8;
   // slave behaviour: 0 none, 1 pulse covering the sample point, 2 pulse ending early
   localparam int V_OD  [NV] = '{0, 0, 1, 1, 0, 0, 1, 1};
   localparam int V_MX  [NV] = '{0, 0, 0, 1, 1, 0, 0, 0};
   localparam int V_SLV [NV] = '{1, 0, 1, 0, 1, 2, 1, 2};
   localparam int V_POKE[NV] = '{0, 0, 0, 0, 0, 0, 1, 0};
   localparam int V_LOW [NV] = '{960, 960, 140, 140, 960, 960, 140, 140};
   localparam int V_HIGH[NV] = '{820, 820, 80, 96, 960, 820, 80, 80};
   localparam int V_PRES[NV] = '{1, 0, 1, 0, 1, 0, 1, 0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, overdrive_i = 1'b0, mixed_i = 1'b0;
   logic slave_pull = 1'b0;
   logic line_oe_o, busy_o, done_o, present_o;
   wire  line_i = !(line_oe_o || slave_pull);

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   swb_reset_seq #(.CLKS_PER_US(CPU)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .overdrive_i(overdrive_i),
      .mixed_i(mixed_i), .line_i(line_i), .line_oe_o(line_oe_o), .busy_o(busy_o),
      .done_o(done_o), .present_o(present_o)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_seq(input int i);
      int lowc, rel, samp;
      samp = V_OD[i] ? 9 * CPU : 70 * CPU;
      @(negedge clk);
      start_i = 1'b1; overdrive_i = V_OD[i][0]; mixed_i = V_MX[i][0];
      @(negedge clk);
      start_i = 1'b0; overdrive_i = ~overdrive_i; mixed_i = ~mixed_i;
      check("R1 oe after start", int'(line_oe_o), 1);
      check("R1 busy after start", int'(busy_o), 1);
      check("R9 present cleared by start", int'(present_o), 0);
      lowc = 0;
      while (line_oe_o) begin
         lowc++;
         if (V_POKE[i] != 0 && lowc == 5) start_i = 1'b1;   // R8 poke during low
         @(negedge clk);
         start_i = 1'b0;
      end
      check(V_OD[i] ? "R3 overdrive low length" : "R2 standard low length", lowc, V_LOW[i]);
      check("R4 low outside forbidden band", int'(lowc <= 80 * CPU || lowc >= 480 * CPU), 1);
      rel = 0;
      while (!done_o) begin
         case (V_SLV[i])
            1: slave_pull = (rel >= samp - 5) && (rel <= samp + 2);
            2: slave_pull = (rel >= 1) && (rel <= samp - 8);
            default: slave_pull = 1'b0;
         endcase
         if (V_POKE[i] != 0 && rel == 5) start_i = 1'b1;    // R8 poke during high
         rel++;
         @(negedge clk);
         start_i = 1'b0;
      end
      slave_pull = 1'b0;
      check(V_MX[i] ? "R7 mixed high window" : "R6 high window", rel, V_HIGH[i]);
      check("R5 presence result", int'(present_o), V_PRES[i]);
      check("R9 busy low with done", int'(busy_o), 0);
      @(negedge clk);
      check("R9 done single cycle", int'(done_o), 0);
      check("R9 present held", int'(present_o), V_PRES[i]);
      if (V_POKE[i] != 0) check("R8 no restart after poke", int'(busy_o), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R10 reset oe", int'(line_oe_o), 0);
      check("R10 reset busy", int'(busy_o), 0);
      check("R10 reset done", int'(done_o), 0);
      check("R10 reset present", int'(present_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      for (int i = 0; i < NV; i++) run_seq(i);

      // R10: reset in the middle of a low pulse
      @(negedge clk);
      start_i = 1'b1; overdrive_i = 1'b0; mixed_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      repeat (20) @(negedge clk);
      check("R10 oe before mid reset", int'(line_oe_o), 1);
      rst_n = 1'b0;
      #1;
      check("R10 mid reset oe", int'(line_oe_o), 0);
      check("R10 mid reset busy", int'(busy_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 idle after mid reset", int'(busy_o), 0);
      // after reset the block works again (R3 overdrive)
      run_seq(2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule